// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This controller lets a clocked system read and write an external asynchronous static RAM of 256K words of 16 bits. The system side presents one request at a time. Each request carries a direction, an 18-bit word address, 16-bit write data and two byte-lane enables. The controller answers with a one-cycle completion pulse and, for reads, the captured word. On the memory side it drives active-low chip select, read enable, write strobe and two byte strobes. It also drives an output value and an output-enable for the shared data bus, and it observes the bus value coming back from the memory.

Every memory timing window is a parameter in nanoseconds. Each window is turned into a cycle count by rounding the interval divided by the clock period up to the next whole cycle. A sequencer steps through setup, pulse, hold, wait, capture and bus-release phases, using one shared down-counter. All memory-side strobes come from registers, so they do not glitch. Between accesses the memory is left in standby.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and in every cycle in which `req_ready` is high, `sram_ce_n`, `sram_oe_n`, `sram_we_n`, `sram_ub_n` and `sram_lb_n` are all 1 and `sram_dq_oe` is 0.
- R2: A request is taken only in a cycle where `req_ready` is 1. `req_ready` stays 0 until that access has finished. `rsp_done` is high for exactly one cycle per request.
- R3: A write drives `sram_we_n` low for `ceil(max(40, 25, 50 - clk) ns / clk)` consecutive cycles (4 at 10 ns), with `sram_ce_n` low and at least one byte strobe low. The address and the bus data are stable from one cycle before the pulse to one cycle after it, so that address setup to the end of the write is at least 50 ns.
- R4: `req_be[0]` selects bits 7:0 through `sram_lb_n`, and `req_be[1]` selects bits 15:8 through `sram_ub_n`. A write changes only the enabled lanes of the word.
- R5: A read holds `sram_we_n` high and `sram_ce_n` and `sram_oe_n` low. It samples the bus only after the longest of the read-cycle, address-access and read-enable-access times (55, 55 and 30 ns). In `rsp_rdata`, enabled lanes carry the memory data and disabled lanes read as zero.
- R6: `sram_dq_oe` is high only in write phases and is never high while `sram_oe_n` is low.
- R7: After a read, the controller does not drive the bus until at least 20 ns after `sram_oe_n` has returned high.
- R8: A request with `req_be` equal to 2'b00 produces no memory strobe. It completes with `rsp_done` in the cycle right after acceptance, and `req_ready` stays high.
- R9: `rsp_done` rises `1 + pulse + hold` cycles after the accepting edge for a write (6 at defaults). For a read it rises after the access-wait cycle count (6 at defaults). Here hold is `max(1, ceil(55 ns / clk) - 1 - pulse)`.
- R10: Address, write data, direction and byte enables are registered at acceptance. Changing the request inputs during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Controller idle; a request is taken this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read word |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Read enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_ub_n | output | 1 | Upper byte strobe, active low |
| sram_lb_n | output | 1 | Lower byte strobe, active low |
| sram_dq_o | output | 16 | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus output enable |
| sram_dq_i | input | 16 | Value seen on the data bus |

## Verification
The bench memory model drives junk on the bus until the access time has passed. A controller that samples even one cycle early therefore returns a wrong word. The model also keeps driving for the release window after the read enable rises, so a missing or short turnaround shows up as bus contention when a write follows a read. Lane-masked writes followed by full reads expose a swapped or ignored byte strobe. Zero-enable requests must finish quietly, and request inputs are scrambled during each access, so any strobe activity or a change to the wrong word is caught.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and cycle arithmetic for the asynchronous SRAM controller.
// Assumes all timing values are positive nanosecond integers.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_SETUP,
        S_RD_WAIT,
        S_RD_CAPTURE,
        S_WR_SETUP,
        S_WR_PULSE,
        S_WR_HOLD,
        S_TURNAROUND
    } ctrl_state_t;

    // Whole clock cycles needed to cover an interval of ns nanoseconds.
    function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
// Shared phase timer: loads a count on phase entry, then counts down to zero.
// Assumes the sequencer loads one less than the phase length in cycles.
module sram_ctrl_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
// Access sequencer: walks the read and write phases and asks the timer for
// each phase length. It takes requests only in S_IDLE.
// Assumes every phase length is at least 1 and the read wait is at least 2.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned N_PULSE  = 4,
    parameter int unsigned N_HOLD   = 1,
    parameter int unsigned N_RWAIT  = 6,
    parameter int unsigned N_TA_RD  = 1,
    parameter int unsigned N_TA_WR  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_none,
    input  logic             timer_expired,
    output ctrl_state_t      state_q,
    output ctrl_state_t      state_d,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             accept,
    output logic             capture,
    output logic             done_set
);

    // Next phase, timer loads and strobes for accept, capture and completion.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        capture    = 1'b0;
        done_set   = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_none) begin
                        done_set = 1'b1;
                    end else if (req_write) begin
                        state_d = S_WR_SETUP;
                    end else begin
                        state_d = S_RD_SETUP;
                    end
                end
            end
            S_WR_SETUP: begin
                state_d    = S_WR_PULSE;
                timer_load = 1'b1;
                timer_val  = CNT_W'(N_PULSE - 1);
            end
            S_WR_PULSE: begin
                if (timer_expired) begin
                    state_d    = S_WR_HOLD;
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(N_HOLD - 1);
                end
            end
            S_WR_HOLD: begin
                if (timer_expired) begin
                    state_d    = S_TURNAROUND;
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(N_TA_WR - 1);
                    done_set   = 1'b1;
                end
            end
            S_RD_SETUP: begin
                state_d    = S_RD_WAIT;
                timer_load = 1'b1;
                timer_val  = CNT_W'(N_RWAIT - 2);
            end
            S_RD_WAIT: begin
                if (timer_expired) begin
                    state_d  = S_RD_CAPTURE;
                    capture  = 1'b1;
                    done_set = 1'b1;
                end
            end
            S_RD_CAPTURE: begin
                state_d    = S_TURNAROUND;
                timer_load = 1'b1;
                timer_val  = CNT_W'(N_TA_RD - 1);
            end
            S_TURNAROUND: begin
                if (timer_expired) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // The capture phase is reached only from the access wait.
    assert_capture_from_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_CAPTURE) |-> ($past(state_q) == S_RD_WAIT));

    // Write setup starts only from the idle phase.
    assert_setup_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_WR_SETUP) |-> ($past(state_q) == S_IDLE));

endmodule

// File: rtl/sram_ctrl_pins.sv
`timescale 1ns/1ps
// Memory-side strobe registers: decodes the next phase and the next lane
// enables into glitch-free, registered active-low pin levels.
// Assumes be_d already reflects a request accepted in the same cycle.
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  ctrl_state_t state_d,
    input  logic [1:0]  be_d,
    output logic        ce_n,
    output logic        oe_n,
    output logic        we_n,
    output logic        ub_n,
    output logic        lb_n,
    output logic        dq_oe
);

    logic in_access;
    logic in_read;
    logic in_write;

    // Classify the upcoming phase.
    always_comb begin
        in_read  = (state_d == S_RD_SETUP) || (state_d == S_RD_WAIT);
        in_write = (state_d == S_WR_SETUP) || (state_d == S_WR_PULSE) ||
                   (state_d == S_WR_HOLD);
        in_access = in_read || in_write;
    end

    // Register every pin level so that the memory sees clean edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            ub_n  <= 1'b1;
            lb_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            ce_n  <= !in_access;
            oe_n  <= !in_read;
            we_n  <= !(state_d == S_WR_PULSE);
            ub_n  <= !(in_access && be_d[1]);
            lb_n  <= !(in_access && be_d[0]);
            dq_oe <= in_write;
        end
    end

    // The chip is never selected without a byte strobe.
    assert_select_has_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> (!ub_n || !lb_n));

    // Read enable and the bus driver are never on together.
    assert_no_bus_fight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
// Asynchronous SRAM controller top: registers the request, runs the sequencer
// and timer, drives the memory pins and captures read data.
// Assumes one request in flight, the clock period CLK_NS and the memory
// timing values given as nanosecond parameters.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_NS    = 10,
    parameter int unsigned T_WC_NS   = 55,
    parameter int unsigned T_PWE_NS  = 40,
    parameter int unsigned T_AW_NS   = 50,
    parameter int unsigned T_SD_NS   = 25,
    parameter int unsigned T_RC_NS   = 55,
    parameter int unsigned T_AA_NS   = 55,
    parameter int unsigned T_DOE_NS  = 30,
    parameter int unsigned T_HZOE_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_ub_n,
    output logic              sram_lb_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);

    localparam int unsigned LANE_W  = DATA_W / 2;
    localparam int unsigned N_PULSE = umax(1, umax(cyc_of(T_PWE_NS, CLK_NS),
                                      umax(cyc_of(T_SD_NS, CLK_NS),
                                           cyc_of(T_AW_NS, CLK_NS) - 1)));
    localparam int unsigned N_HOLD  = umax(1, cyc_of(T_WC_NS, CLK_NS) - 1 - N_PULSE);
    localparam int unsigned N_RWAIT = umax(2, umax(cyc_of(T_AA_NS, CLK_NS),
                                      umax(cyc_of(T_DOE_NS, CLK_NS),
                                           cyc_of(T_RC_NS, CLK_NS))));
    localparam int unsigned N_TA_RD = umax(1, cyc_of(T_HZOE_NS, CLK_NS) - 1);
    localparam int unsigned N_TA_WR = 1;
    localparam int unsigned N_MAX   = umax(umax(N_PULSE, N_HOLD), umax(N_RWAIT, N_TA_RD));
    localparam int unsigned CNT_W   = $clog2(N_MAX + 1) + 1;

    ctrl_state_t       state_q;
    ctrl_state_t       state_d;
    logic              timer_load;
    logic [CNT_W-1:0]  timer_val;
    logic              timer_expired;
    logic              accept;
    logic              capture;
    logic              done_set;
    logic [1:0]        be_q;
    logic [1:0]        be_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    assign be_d = accept ? req_be : be_q;

    sram_ctrl_seq #(
        .CNT_W   (CNT_W),
        .N_PULSE (N_PULSE),
        .N_HOLD  (N_HOLD),
        .N_RWAIT (N_RWAIT),
        .N_TA_RD (N_TA_RD),
        .N_TA_WR (N_TA_WR)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_none      (req_be == 2'b00),
        .timer_expired (timer_expired),
        .state_q       (state_q),
        .state_d       (state_d),
        .timer_load    (timer_load),
        .timer_val     (timer_val),
        .accept        (accept),
        .capture       (capture),
        .done_set      (done_set)
    );

    sram_ctrl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_expired)
    );

    sram_ctrl_pins u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .be_d    (be_d),
        .ce_n    (sram_ce_n),
        .oe_n    (sram_oe_n),
        .we_n    (sram_we_n),
        .ub_n    (sram_ub_n),
        .lb_n    (sram_lb_n),
        .dq_oe   (sram_dq_oe)
    );

    // Hold the accepted request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Completion pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_set;
        end
    end

    // Per-lane read capture; lanes that were not enabled read as zero.
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata_q[ln*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata_q[ln*LANE_W +: LANE_W] <= be_q[ln] ? sram_dq_i[ln*LANE_W +: LANE_W] : '0;
            end
        end
    end

    assign req_ready = (state_q == S_IDLE);
    assign rsp_done  = done_q;
    assign rsp_rdata = rdata_q;
    assign sram_addr = addr_q;
    assign sram_dq_o = wdata_q;

    // While idle the memory sits in standby and the bus is released.
    assert_standby_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && sram_ub_n &&
                       sram_lb_n && !sram_dq_oe));

    // A completion from a real access lasts one cycle.
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !req_ready) |=> !rsp_done);

    // The write strobe is only active while selected, with read off and a lane on.
    assert_write_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && (!sram_ub_n || !sram_lb_n)));

    // Address and data do not move inside the write pulse, and the bus is driven.
    assert_write_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && $past(!sram_we_n)) |->
            ($stable(sram_addr) && $stable(sram_dq_o) && sram_dq_oe));

    // A read phase never has the write strobe active.
    assert_read_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> sram_we_n);

endmodule

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: timed memory model plus random and directed requests.
module sim_sram_ctrl;

    localparam int CLK_NS  = 10;
    localparam int T_WC    = 55;
    localparam int T_PWE   = 40;
    localparam int T_AW    = 50;
    localparam int T_SD    = 25;
    localparam int T_AA    = 55;
    localparam int T_DOE   = 30;
    localparam int T_HZOE  = 20;
    localparam int WD_LIMIT = 100000;

    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_PULSE = mx(1, mx(cdiv(T_PWE), mx(cdiv(T_SD), cdiv(T_AW) - 1)));
    localparam int E_HOLD  = mx(1, cdiv(T_WC) - 1 - E_PULSE);
    localparam int LAT_WR  = 1 + E_PULSE + E_HOLD;
    localparam int LAT_RD  = mx(2, mx(cdiv(T_AA), mx(cdiv(T_DOE), cdiv(T_WC))));

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [17:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_be;
    logic        req_ready;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n;
    logic [15:0] sram_dq_o;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_i;

    int n_checks = 0;
    int n_errors = 0;

    sram_ctrl #(.CLK_NS(CLK_NS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    initial clk = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Memory contents held by the model and the bench's own expectation.
    logic [15:0] mem    [logic [17:0]];
    logic [15:0] shadow [logic [17:0]];

    function automatic logic [15:0] mem_rd(input logic [17:0] a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction
    function automatic logic [15:0] shadow_rd(input logic [17:0] a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    // Model state.
    bit          rd_prev = 0, rel_seen = 0, wr_prev = 0, wr_bad = 0;
    time         t_rd_start = 0, t_rel = 0;
    logic [17:0] rd_addr = '0, wr_addr = '0, su_addr = '0;
    logic [1:0]  rd_lanes = '0, wr_lanes = '0;
    logic [15:0] wr_data = '0, drv_word = 16'hC3C3;
    int          wr_cnt = 0, su_cnt = 0, ce_low_count = 0;

    assign sram_dq_i = drv_word;

    // Timed memory model, sampled away from the active edge.
    always @(negedge clk) begin
        bit rd_now, wr_now, hz, drv_on, valid;
        logic [15:0] w;
        if (rst_n) begin
            if (!sram_ce_n) ce_low_count++;
            rd_now = !sram_ce_n && !sram_oe_n && sram_we_n;
            if (rd_now) begin
                if (!rd_prev || sram_addr != rd_addr) begin
                    t_rd_start = $time - CLK_NS / 2;
                    rd_addr = sram_addr;
                end
                rd_lanes = {!sram_ub_n, !sram_lb_n};
            end else if (rd_prev) begin
                t_rel = $time - CLK_NS / 2;
                rel_seen = 1;
            end
            rd_prev = rd_now;
            hz = !rd_now && rel_seen && (($time - t_rel) < T_HZOE);
            drv_on = rd_now || hz;
            valid = rd_now && (($time - t_rd_start) >= T_AA);
            w = mem_rd(rd_addr);
            for (int l = 0; l < 2; l++) begin
                if (drv_on && rd_lanes[l]) drv_word[l*8 +: 8] = valid ? w[l*8 +: 8] : 8'h5A;
                else drv_word[l*8 +: 8] = 8'hC3;
            end
            // R7/R6: the controller must not drive while the memory may still drive.
            if (drv_on && sram_dq_oe)
                check(1'b0, "R7", "bus driven while memory drives", 32'd1, 32'd0);

            wr_now = !sram_ce_n && !sram_we_n && (!sram_ub_n || !sram_lb_n);
            if (wr_now) begin
                if (!wr_prev) begin
                    wr_cnt = 0; wr_addr = sram_addr; wr_data = sram_dq_o; wr_bad = 0;
                end
                wr_cnt++;
                if (sram_addr != wr_addr || sram_dq_o != wr_data || !sram_dq_oe) wr_bad = 1;
                wr_lanes = {!sram_ub_n, !sram_lb_n};
            end else if (wr_prev) begin
                check(wr_cnt * CLK_NS >= T_PWE, "R3", "write pulse length ns",
                      wr_cnt * CLK_NS, T_PWE);
                check(su_cnt * CLK_NS >= T_AW, "R3", "address setup to write end ns",
                      su_cnt * CLK_NS, T_AW);
                check(!wr_bad && sram_addr == wr_addr && sram_dq_o == wr_data && sram_dq_oe,
                      "R3", "address/data stable through pulse and hold",
                      {16'(sram_addr), sram_dq_o}, {16'(wr_addr), wr_data});
                w = mem_rd(wr_addr);
                for (int l = 0; l < 2; l++)
                    if (wr_lanes[l]) w[l*8 +: 8] = wr_data[l*8 +: 8];
                mem[wr_addr] = w;
            end
            wr_prev = wr_now;
            if (!sram_ce_n) begin
                if (su_cnt == 0 || sram_addr != su_addr) begin
                    su_addr = sram_addr; su_cnt = 0;
                end
                su_cnt++;
            end else begin
                su_cnt = 0;
            end
        end
    end

    // One request from presentation to completion, with all port checks.
    task automatic run_req(input bit wr, input logic [17:0] a, input logic [15:0] d,
                           input logic [1:0] be);
        int lat;
        int ce_before;
        int exp_lat;
        logic [15:0] exp;
        while (!req_ready) @(negedge clk);
        check({sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe} == 6'b111110,
              "R1", "standby pins while ready",
              {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe}, 6'b111110);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        ce_before = ce_low_count;
        @(negedge clk);
        // R10: scramble the request inputs during the access.
        req_valid = 1'b0;
        req_write = 1'($urandom);
        req_addr  = 18'($urandom);
        req_wdata = 16'($urandom);
        req_be    = 2'($urandom);
        if (be != 2'b00) check(!req_ready, "R2", "ready low while busy", req_ready, 0);
        else check(req_ready, "R8", "ready stays high on empty request", req_ready, 1);
        lat = 0;
        while (!rsp_done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = (be == 2'b00) ? 0 : (wr ? LAT_WR : LAT_RD);
        check(lat == exp_lat, (be == 2'b00) ? "R8" : "R9", "done latency", lat, exp_lat);
        if (be == 2'b00) begin
            check(ce_low_count == ce_before, "R8", "no strobes on empty request",
                  ce_low_count - ce_before, 0);
        end else if (wr) begin
            exp = shadow_rd(a);
            for (int l = 0; l < 2; l++)
                if (be[l]) exp[l*8 +: 8] = d[l*8 +: 8];
            shadow[a] = exp;
        end else begin
            exp = shadow_rd(a);
            for (int l = 0; l < 2; l++)
                if (!be[l]) exp[l*8 +: 8] = 8'h00;
            check(rsp_rdata == exp, "R5", "read data (R4 lanes, R10 fields)", rsp_rdata, exp);
        end
        @(negedge clk);
        check(!rsp_done, "R2", "done lasts one cycle", rsp_done, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_be = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_done, "R1", "ready and no done after reset",
              {req_ready, rsp_done}, 2'b10);
        check({sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe} == 6'b111110,
              "R1", "pins after reset",
              {sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n, sram_dq_oe}, 6'b111110);

        // Full-word writes at both address extremes, then read back.
        run_req(1, 18'h00000, 16'h1234, 2'b11);
        run_req(1, 18'h3FFFF, 16'hBEEF, 2'b11);
        run_req(0, 18'h00000, 16'h0000, 2'b11);
        run_req(0, 18'h3FFFF, 16'h0000, 2'b11);
        // R4: lane-masked writes, then full and single-lane reads.
        run_req(1, 18'h00000, 16'hAA55, 2'b01);
        run_req(1, 18'h3FFFF, 16'h7766, 2'b10);
        run_req(0, 18'h00000, 16'h0000, 2'b11);
        run_req(0, 18'h3FFFF, 16'h0000, 2'b01);
        run_req(0, 18'h3FFFF, 16'h0000, 2'b10);
        // R8: empty requests change nothing.
        run_req(1, 18'h00000, 16'hFFFF, 2'b00);
        run_req(0, 18'h00000, 16'h0000, 2'b00);
        run_req(0, 18'h00000, 16'h0000, 2'b11);
        // R7: write straight after a read.
        run_req(0, 18'h3FFFF, 16'h0000, 2'b11);
        run_req(1, 18'h00010, 16'hC0DE, 2'b11);
        run_req(0, 18'h00010, 16'h0000, 2'b11);

        // Random mix over a small address window and the top of memory.
        for (int i = 0; i < 300; i++) begin
            logic [17:0] a;
            a = ($urandom % 4 == 0) ? (18'h3FFFF - 18'($urandom % 4)) : 18'($urandom % 16);
            run_req(1'($urandom), a, 16'($urandom), 2'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule